// File: doc/BRIEF.md
# General Purpose I/O Port Controller

This block is a parameterized general purpose I/O port of WIDTH pins (16 by default) with a small register interface. Every pin has five control bits: direction, output latch, open-drain enable, weak pull-up enable and change-notice enable. Software can write each control register directly, or it can clear, set or toggle selected bits with one write that needs no read-modify-write sequence. The pad side is modelled as separate output-data, output-enable and pull-up vectors plus a raw input vector.

Raw pin inputs pass through a chain of SYNC_STAGES flip-flops on the system clock before they can be read or watched. Any pin can be handed to an alternate peripheral: while the peripheral enables that pin and asserts its output enable, the peripheral drives the pad. A change-notice interrupt flags when an enabled input differs from the level captured at the last port read. This logic runs on the system clock alone and needs no CPU activity, so the interrupt can still wake an idle processor.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, all pins are inputs: the direction register reads all ones, the latch, open-drain, pull-up and change-notice registers read zero, pad_oe and pad_pu are zero, and cn_irq is low.
- R2: The register addresses are 0 direction, 1 latch, 2 open-drain, 3 pull-up, 4 change-notice enable and 5 port. reg_rdata and reg_rd_valid are registered and appear one cycle after reg_rd is sampled. An unused address reads zero.
- R3: A direction bit of 0 makes the pin an output. Without open-drain or override, pad_oe is the inverse of the direction bit and pad_out follows the latch bit. Pad outputs are registered one cycle after the control state changes.
- R4: A read of address 5 returns pad_in after it passes SYNC_STAGES clock edges. A write to address 5 goes to the latch register.
- R5: While alt_en and alt_oe are both 1 for a pin, that pin's pad_oe is 1 and its pad_out is alt_out, whatever its direction, latch and open-drain bits. With only one of the two set, the pin is not overridden.
- R6: With the open-drain bit set on an output pin, latch 0 drives pad_oe 1 and pad_out 0, and latch 1 sets pad_oe to 0. The pad is never driven high.
- R7: reg_op selects the write kind: 0 writes the data, 1 clears, 2 sets and 3 inverts every bit where reg_wdata is 1. Bits where reg_wdata is 0 keep their value.
- R8: pad_pu is 1 only on pins with the pull-up bit set whose direction bit is 1.
- R9: cn_irq rises when a synchronized input with its change-notice bit set differs from the reference captured at the last port read. It stays high until a port read, which clears it and re-captures the reference.
- R10: Changes on pins whose change-notice bit is 0 never raise cn_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_op | input | 2 | Write kind: write, clear, set, invert |
| reg_wdata | input | WIDTH | Write data or bit mask |
| reg_rdata | output | WIDTH | Registered read data |
| reg_rd_valid | output | 1 | Read data valid |
| alt_en | input | WIDTH | Peripheral owns the pin |
| alt_oe | input | WIDTH | Peripheral output enable |
| alt_out | input | WIDTH | Peripheral output data |
| pad_in | input | WIDTH | Raw pad input levels |
| pad_out | output | WIDTH | Pad output data |
| pad_oe | output | WIDTH | Pad output enable |
| pad_pu | output | WIDTH | Pad weak pull-up enable |
| cn_irq | output | 1 | Change-notice interrupt |

## Verification
The bench builds the port with WIDTH at 16 and SYNC_STAGES at 3. The deeper synchronizer separates the input latency from the one-cycle register and pad latency, so a wrong stage count shows up as a wrong value in a port read or a late or early interrupt. The full 16-bit width lets one vector pattern cover, in a single check, output pins, input pins, open-drain pins, overridden pins and pins with change-notice on or off.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_CTL = 5;

  localparam logic [ADDR_W-1:0] A_DIR  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ODC  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PUE  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNE  = 3'd4;
  localparam logic [ADDR_W-1:0] A_PORT = 3'd5;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_SET    = 2'd2,
    OP_INVERT = 2'd3
  } wr_op_e;
endpackage

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           op,
  input  logic [WIDTH-1:0]     wdata,
  output logic [WIDTH-1:0]     dir_o,
  output logic [WIDTH-1:0]     lat_o,
  output logic [WIDTH-1:0]     odc_o,
  output logic [WIDTH-1:0]     pue_o,
  output logic [WIDTH-1:0]     cne_o
);
  logic [WIDTH-1:0] ctl_q [NUM_CTL];

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_ctl
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
    localparam logic [WIDTH-1:0]  RST_VAL = (i == 0) ? '1 : '0;
    logic hit;
    assign hit = wr && ((addr == MY_ADDR) || (i == 1 && addr == A_PORT));

    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q[i] <= RST_VAL;
      end else if (hit) begin
        case (wr_op_e'(op))
          OP_WRITE:  ctl_q[i] <= wdata;
          OP_CLEAR:  ctl_q[i] <= ctl_q[i] & ~wdata;
          OP_SET:    ctl_q[i] <= ctl_q[i] | wdata;
          default:   ctl_q[i] <= ctl_q[i] ^ wdata;
        endcase
      end
    end
  end

  assign dir_o = ctl_q[0];
  assign lat_o = ctl_q[1];
  assign odc_o = ctl_q[2];
  assign pue_o = ctl_q[3];
  assign cne_o = ctl_q[4];

  assert_set_sticks_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && op == OP_SET && addr == A_LAT) |=>
      ((lat_o & $past(wdata)) == $past(wdata)));

  assert_clear_sticks_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && op == OP_CLEAR && addr == A_DIR) |=>
      ((dir_o & $past(wdata)) == '0));

  assert_masked_bits_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && op != OP_WRITE && addr == A_ODC) |=>
      ((odc_o & ~$past(wdata)) == ($past(odc_o) & ~$past(wdata))));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= raw_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] lat_i,
  input  logic [WIDTH-1:0] odc_i,
  input  logic [WIDTH-1:0] pue_i,
  input  logic [WIDTH-1:0] alt_en,
  input  logic [WIDTH-1:0] alt_oe,
  input  logic [WIDTH-1:0] alt_out,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);
  logic [WIDTH-1:0] ovr, out_d, oe_d;

  assign ovr = alt_en & alt_oe;

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    always_comb begin
      if (ovr[p]) begin
        out_d[p] = alt_out[p];
        oe_d[p]  = 1'b1;
      end else if (odc_i[p]) begin
        out_d[p] = 1'b0;
        oe_d[p]  = ~dir_i[p] & ~lat_i[p];
      end else begin
        out_d[p] = lat_i[p];
        oe_d[p]  = ~dir_i[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pad_pu  <= '0;
    end else begin
      pad_out <= out_d;
      pad_oe  <= oe_d;
      pad_pu  <= pue_i & dir_i;
    end
  end

  assert_override_drives_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pad_oe & $past(ovr)) == $past(ovr)) &&
              ((pad_out & $past(ovr)) == ($past(alt_out) & $past(ovr)))));

  assert_od_never_high_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_out & pad_oe & $past(odc_i & ~ovr)) == '0));

  assert_pullup_inputs_only_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_pu & ~$past(dir_i)) == '0));
endmodule

// File: rtl/gpio_cn.sv
module gpio_cn #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] cne_i,
  input  logic             port_rd,
  output logic             cn_flag
);
  logic [WIDTH-1:0] ref_q;
  logic             diff;

  assign diff = |((sync_i ^ ref_q) & cne_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= '0;
      cn_flag <= 1'b0;
    end else if (port_rd) begin
      ref_q   <= sync_i;
      cn_flag <= 1'b0;
    end else if (diff) begin
      cn_flag <= 1'b1;
    end
  end

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
    port_rd |=> !cn_flag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (cn_flag && !port_rd) |=> cn_flag);

  assert_quiet_when_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    ($rose(cn_flag)) |-> ($past(cne_i) != '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [2:0]           reg_addr,
  input  logic [1:0]           reg_op,
  input  logic [WIDTH-1:0]     reg_wdata,
  output logic [WIDTH-1:0]     reg_rdata,
  output logic                 reg_rd_valid,
  input  logic [WIDTH-1:0]     alt_en,
  input  logic [WIDTH-1:0]     alt_oe,
  input  logic [WIDTH-1:0]     alt_out,
  input  logic [WIDTH-1:0]     pad_in,
  output logic [WIDTH-1:0]     pad_out,
  output logic [WIDTH-1:0]     pad_oe,
  output logic [WIDTH-1:0]     pad_pu,
  output logic                 cn_irq
);
  logic [WIDTH-1:0] dir_q, lat_q, odc_q, pue_q, cne_q, pin_sync;
  logic [WIDTH-1:0] rd_mux;
  logic             port_rd;

  assign port_rd = reg_rd && (reg_addr == A_PORT);

  gpio_ctl_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .op(reg_op),
    .wdata(reg_wdata), .dir_o(dir_q), .lat_o(lat_q), .odc_o(odc_q),
    .pue_o(pue_q), .cne_o(cne_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_i(pad_in), .sync_o(pin_sync)
  );

  gpio_pad_mux #(.WIDTH(WIDTH)) u_mux (
    .clk(clk), .rst(rst), .dir_i(dir_q), .lat_i(lat_q), .odc_i(odc_q),
    .pue_i(pue_q), .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  gpio_cn #(.WIDTH(WIDTH)) u_cn (
    .clk(clk), .rst(rst), .sync_i(pin_sync), .cne_i(cne_q),
    .port_rd(port_rd), .cn_flag(cn_irq)
  );

  always_comb begin
    case (reg_addr)
      A_DIR:   rd_mux = dir_q;
      A_LAT:   rd_mux = lat_q;
      A_ODC:   rd_mux = odc_q;
      A_PUE:   rd_mux = pue_q;
      A_CNE:   rd_mux = cne_q;
      A_PORT:  rd_mux = pin_sync;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata    <= '0;
      reg_rd_valid <= 1'b0;
    end else begin
      reg_rd_valid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rd_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !reg_rd_valid);
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int W  = 16;
  localparam int SS = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          reg_wr, reg_rd;
  logic [2:0]    reg_addr;
  logic [1:0]    reg_op;
  logic [W-1:0]  reg_wdata, reg_rdata;
  logic          reg_rd_valid;
  logic [W-1:0]  alt_en, alt_oe, alt_out, pad_in;
  logic [W-1:0]  pad_out, pad_oe, pad_pu;
  logic          cn_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [W-1:0] exp_q [$];
  string        tag_q [$];

  always #5 clk = ~clk;

  gpio_port #(.WIDTH(W), .SYNC_STAGES(SS)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_op(reg_op), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rd_valid(reg_rd_valid),
    .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .cn_irq(cn_irq)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when read data comes out
  always @(negedge clk) begin
    if (!rst && reg_rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected read data", reg_rdata, '1 ^ reg_rdata);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, reg_rdata, e);
      end
    end
  end

  task automatic reg_write(logic [2:0] a, logic [1:0] op, logic [W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_op = op; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, logic [W-1:0] exp, string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    @(posedge clk);
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_edges(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_op = 0;
    reg_wdata = 0; alt_en = 0; alt_oe = 0; alt_out = 0; pad_in = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, 16'h0000);
    check("R1 pad_pu", pad_pu, 16'h0000);
    check("R1 cn_irq", {15'd0, cn_irq}, 16'h0000);
    reg_read(3'd0, 16'hFFFF, "R1 dir reset");
    reg_read(3'd1, 16'h0000, "R1 lat reset");
    reg_read(3'd2, 16'h0000, "R1 odc reset");
    reg_read(3'd3, 16'h0000, "R1 pue reset");
    reg_read(3'd4, 16'h0000, "R1 cne reset");

    // R2/R3 direct writes, readback, output drive
    reg_write(3'd1, 2'd0, 16'hA5C3);
    reg_write(3'd0, 2'd0, 16'hFF00);
    reg_read(3'd1, 16'hA5C3, "R2 lat readback");
    reg_read(3'd0, 16'hFF00, "R2 dir readback");
    reg_read(3'd7, 16'h0000, "R2 unused address");
    settle();
    check("R3 pad_oe outputs", pad_oe, 16'h00FF);
    check("R3 pad_out driven", pad_out & pad_oe, 16'h00C3);

    // R7 clear/set/invert, R4 write alias via port address
    reg_write(3'd1, 2'd2, 16'h0004);
    reg_read(3'd1, 16'hA5C7, "R7 set");
    reg_write(3'd1, 2'd1, 16'h0080);
    reg_read(3'd1, 16'hA547, "R7 clear");
    reg_write(3'd1, 2'd3, 16'h00FF);
    reg_read(3'd1, 16'hA5B8, "R7 invert");
    reg_write(3'd5, 2'd2, 16'h0200);
    reg_read(3'd1, 16'hA7B8, "R4 port write to latch");

    // R6 open drain on pins 0..3, latch low nibble 8
    reg_write(3'd2, 2'd0, 16'h000F);
    settle();
    check("R6 od pad_oe", pad_oe, 16'h00F7);
    check("R6 od pad_out", pad_out & pad_oe, 16'h00B0);

    // R8 pull-ups only on inputs
    reg_write(3'd3, 2'd0, 16'h0F0F);
    settle();
    check("R8 pad_pu", pad_pu, 16'h0F00);

    // R5 peripheral override on pin 15; pin 0 enabled without oe, pin 1 oe without enable
    @(negedge clk);
    alt_en = 16'h8001; alt_oe = 16'h8002; alt_out = 16'h8003;
    settle();
    check("R5 override pad_oe", pad_oe, 16'h80F7);
    check("R5 override pad_out", pad_out & pad_oe, 16'h80B0);
    @(negedge clk);
    alt_en = 0; alt_oe = 0; alt_out = 0;
    settle();
    check("R5 release", pad_oe, 16'h00F7);

    // R4 synchronized port read
    @(negedge clk);
    pad_in = 16'h1234;
    wait_edges(SS);
    reg_read(3'd5, 16'h1234, "R4 port read");

    // R9 change notice on pins 0..3
    reg_write(3'd4, 2'd0, 16'h000F);
    check("R9 no change yet", {15'd0, cn_irq}, 16'h0000);
    @(negedge clk);
    pad_in = 16'h1230;
    wait_edges(SS);
    check("R9 not before sync+flag", {15'd0, cn_irq}, 16'h0000);
    wait_edges(1);
    check("R9 flag set", {15'd0, cn_irq}, 16'h0001);
    wait_edges(3);
    check("R9 flag sticky", {15'd0, cn_irq}, 16'h0001);
    reg_read(3'd5, 16'h1230, "R9 port read clears");
    @(negedge clk);
    check("R9 flag cleared", {15'd0, cn_irq}, 16'h0000);

    // R10 change on disabled pin 15
    pad_in = 16'h9230;
    wait_edges(SS + 3);
    check("R10 disabled pin quiet", {15'd0, cn_irq}, 16'h0000);
    reg_read(3'd5, 16'h9230, "R10 port shows new level");

    wait_edges(3);
    check("R2 scoreboard drained", 16'(exp_q.size()), 16'h0000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule